// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a logical address, made of a segment number and an offset, into a physical address. The per-segment descriptors live in a word-addressed table memory that the unit reads through a single read port. Two context registers locate the table and bound it. The table origin gives the word address where descriptor 0 starts. The table size gives the count of valid segments. Software programs both through a small write port. A context switch consists only of rewriting these two registers.

Each request enters through a valid/ready handshake, and only one request is handled at a time. The segment number is compared with the table size first. An out-of-range segment faults at once and causes no memory traffic. For a legal segment the unit reads the descriptor's limit word and compares the offset with it. Only if the offset is in bounds does it read the base word and add the offset to it. The result, or an addressing-error flag, is held on the response port until it is accepted.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset the response port is idle (rsp_valid=0), req_ready=1, no table read is issued, and the table size is 0, so every request faults.
- R2: A request whose segment number is greater than or equal to the table size gets a fault response (rsp_fault=1) with no table read, and rsp_valid rises right after the accepting clock edge.
- R3: For a legal segment s, the descriptor occupies two consecutive words. The limit word is read first from origin+2*s, and the base word is read in the next cycle from origin+2*s+1. Read data arrives one cycle after mem_rd_en.
- R4: If the offset is greater than or equal to the limit word, the response is a fault, the base word is not read, and rsp_valid rises on the second clock edge after acceptance. A limit of 0 therefore always faults.
- R5: If the offset is below the limit, the response has rsp_fault=0 and rsp_addr = base + offset modulo 2^PA_W. rsp_valid rises on the third clock edge after acceptance.
- R6: A response stays valid with an unchanged address and fault flag until rsp_ready is seen high. While a response is pending or a translation is running, req_ready is 0.
- R7: A write with cfg_sel=0 loads the table origin and a write with cfg_sel=1 loads the table size. Writes take effect only while the unit is idle. Writes made during a translation are dropped, and req_ready is 0 during a write cycle.
- R8: A faulting response drives rsp_addr to 0, and the unit never issues a table read for a segment at or beyond the table size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Context register write strobe |
| cfg_sel | input | 1 | 0 = table origin, 1 = table size |
| cfg_wdata | input | MEM_AW | Write data (size uses the low SEG_W+1 bits) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_addr | output | PA_W | Physical address (0 on fault) |
| rsp_fault | output | 1 | Addressing-error trap |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | MEM_AW | Table word address |
| mem_rd_data | input | PA_W | Table read data, one cycle after the strobe |

## Verification
The bench drives offsets exactly at limit-1 and at the limit. A design that used a less-or-equal compare would pass the second one through instead of trapping it. It also runs a zero-length descriptor and a base near the top of the address range, which exposes a design that faults on wraparound or mishandles an empty segment. It counts table reads for out-of-range segments and for out-of-bounds offsets, so a design that fetches speculatively or reads the base word before the limit word is caught. Finally, it rewrites the table size during a translation and checks that the next request still sees the old value, which shows whether context writes leak into work already in progress.

// File: rtl/segx_pkg.sv
package segx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LIM  = 3'd1,
        ST_CHK  = 3'd2,
        ST_ADD  = 3'd3,
        ST_RESP = 3'd4
    } xl_state_e;

    typedef enum logic {
        CFG_ORIGIN = 1'b0,
        CFG_SIZE   = 1'b1
    } cfg_sel_e;

    // Descriptor layout: limit word first, base word second.
    localparam int unsigned DESC_WORDS = 2;
    localparam int unsigned LIMIT_IDX  = 0;
    localparam int unsigned BASE_IDX   = 1;

    typedef struct packed {
        logic fault;
        logic go_on;
    } chk_result_t;

endpackage

// File: rtl/seg_ctx_regs.sv
module seg_ctx_regs
    import segx_pkg::*;
#(
    parameter int unsigned AW    = 10,
    parameter int unsigned SEG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    output logic [AW-1:0]    origin,
    output logic [SEG_W:0]   size
);
    localparam int unsigned SZ_W = SEG_W + 1;

    logic wr_ok;
    assign wr_ok = cfg_we && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            origin <= '0;
            size   <= '0;
        end else if (wr_ok) begin
            if (cfg_sel_e'(cfg_sel) == CFG_ORIGIN)
                origin <= cfg_wdata;
            else
                size <= cfg_wdata[SZ_W-1:0];
        end
    end

    // R7: context stays frozen while a translation is in flight
    p_ctx_frozen_busy_r7: assert property (@(posedge clk) disable iff (rst)
        !idle |=> ($stable(origin) && $stable(size)));

endmodule

// File: rtl/seg_bound_cmp.sv
module seg_bound_cmp
    import segx_pkg::*;
#(
    parameter int unsigned SEG_W = 4,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned PA_W  = 16
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [SEG_W:0]   size,
    input  logic [OFF_W-1:0] off,
    input  logic [PA_W-1:0]  limit,
    output logic             seg_ok,
    output logic             off_ok
);
    logic [PA_W-1:0] off_ext;

    assign off_ext = PA_W'(off);
    assign seg_ok  = ({1'b0, seg} < size);
    assign off_ok  = (off_ext < limit);

endmodule

// File: rtl/seg_entry_addr.sv
module seg_entry_addr
    import segx_pkg::*;
#(
    parameter int unsigned AW    = 10,
    parameter int unsigned SEG_W = 4
) (
    input  logic [AW-1:0]    origin,
    input  logic [SEG_W-1:0] seg,
    output logic [AW-1:0]    lim_addr,
    output logic [AW-1:0]    base_addr
);
    logic [AW-1:0] slot;

    assign slot      = AW'(seg) * AW'(DESC_WORDS);
    assign lim_addr  = origin + slot + AW'(LIMIT_IDX);
    assign base_addr = origin + slot + AW'(BASE_IDX);

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import segx_pkg::*;
#(
    parameter int unsigned SEG_W  = 4,
    parameter int unsigned OFF_W  = 12,
    parameter int unsigned PA_W   = 16,
    parameter int unsigned MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [MEM_AW-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_addr,
    output logic              rsp_fault,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic [PA_W-1:0]   mem_rd_data
);
    xl_state_e         state;
    logic [SEG_W-1:0]  seg_q;
    logic [OFF_W-1:0]  off_q;
    logic [MEM_AW-1:0] origin;
    logic [SEG_W:0]    size;
    logic [MEM_AW-1:0] lim_addr;
    logic [MEM_AW-1:0] base_addr;
    logic              seg_ok;
    logic              off_ok;
    logic              idle;
    chk_result_t       chk;

    assign idle = (state == ST_IDLE);

    seg_ctx_regs #(.AW(MEM_AW), .SEG_W(SEG_W)) u_ctx (
        .clk       (clk),
        .rst       (rst),
        .idle      (idle),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .origin    (origin),
        .size      (size)
    );

    seg_bound_cmp #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_cmp (
        .seg    (req_seg),
        .size   (size),
        .off    (off_q),
        .limit  (mem_rd_data),
        .seg_ok (seg_ok),
        .off_ok (off_ok)
    );

    seg_entry_addr #(.AW(MEM_AW), .SEG_W(SEG_W)) u_addr (
        .origin    (origin),
        .seg       (seg_q),
        .lim_addr  (lim_addr),
        .base_addr (base_addr)
    );

    // A context write wins over a request in the same cycle.
    assign req_ready   = idle && !cfg_we;
    assign rsp_valid   = (state == ST_RESP);
    assign chk.fault   = !off_ok;
    assign chk.go_on   = off_ok;
    assign mem_rd_en   = (state == ST_LIM) || ((state == ST_CHK) && chk.go_on);
    assign mem_rd_addr = (state == ST_LIM) ? lim_addr : base_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            seg_q     <= '0;
            off_q     <= '0;
            rsp_addr  <= '0;
            rsp_fault <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid && req_ready) begin
                        seg_q <= req_seg;
                        off_q <= req_off;
                        if (seg_ok) begin
                            state <= ST_LIM;
                        end else begin
                            rsp_addr  <= '0;
                            rsp_fault <= 1'b1;
                            state     <= ST_RESP;
                        end
                    end
                end
                ST_LIM: state <= ST_CHK;
                ST_CHK: begin
                    if (chk.fault) begin
                        rsp_addr  <= '0;
                        rsp_fault <= 1'b1;
                        state     <= ST_RESP;
                    end else begin
                        state <= ST_ADD;
                    end
                end
                ST_ADD: begin
                    rsp_addr  <= mem_rd_data + PA_W'(off_q);
                    rsp_fault <= 1'b0;
                    state     <= ST_RESP;
                end
                ST_RESP: begin
                    if (rsp_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: response held until taken
    p_rsp_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));

    // R6: no new request while a response is pending
    p_busy_no_accept_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    // R3: back-to-back reads walk to the next descriptor word
    p_base_after_limit_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + 1'b1));

    // R4: the base word is fetched only when the limit covers the offset
    p_base_only_in_bounds_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && $past(mem_rd_en)) |-> (PA_W'(off_q) < mem_rd_data));

    // R8: no table read for an out-of-range segment
    p_read_legal_seg_r8: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> ({1'b0, seg_q} < size));

    // R8: faults carry a zero address
    p_fault_zero_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_addr == '0));

endmodule

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;

    localparam int SEG_W = 4, OFF_W = 12, PA_W = 16, MEM_AW = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic              cfg_sel = 1'b0;
    logic [MEM_AW-1:0] cfg_wdata = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [SEG_W-1:0]  req_seg = '0;
    logic [OFF_W-1:0]  req_off = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [PA_W-1:0]   rsp_addr;
    logic              rsp_fault;
    logic              mem_rd_en;
    logic [MEM_AW-1:0] mem_rd_addr;
    logic [PA_W-1:0]   mem_rd_data = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    seg_xlate_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .MEM_AW(MEM_AW)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg), .req_off(req_off),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
    );

    // Table memory model: one-cycle read latency
    logic [PA_W-1:0]   tmem [0:63];
    int                rd_total = 0;
    logic [MEM_AW-1:0] prev_ra = '0, last_ra = '0;
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= tmem[mem_rd_addr[5:0]];
            rd_total    <= rd_total + 1;
            prev_ra     <= last_ra;
            last_ra     <= mem_rd_addr;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = MEM_AW'(val);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request, wait for the response, check it is held, then accept it.
    task automatic xlate(input int seg, input int off, output int addr, output bit flt,
                         output int reads, output int lat);
        int r0;
        @(negedge clk);
        r0 = rd_total;
        req_valid = 1'b1; req_seg = SEG_W'(seg); req_off = OFF_W'(off);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        addr  = int'(rsp_addr);
        flt   = rsp_fault;
        reads = rd_total - r0;
        @(negedge clk);
        check(rsp_valid && int'(rsp_addr) == addr && rsp_fault == flt, "R6 hold", int'(rsp_addr), addr);
        check(!req_ready, "R6 req_ready low while pending", int'(req_ready), 0);
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
        check(!rsp_valid && req_ready, "R6 released", int'(rsp_valid), 0);
    endtask

    typedef struct packed {
        logic [3:0]  seg;
        logic [11:0] off;
        logic [15:0] addr;
        logic        flt;
        logic [1:0]  reads;
        logic [1:0]  lat;
    } vec_t;

    // origin 8, size 4: seg0 lim 100 base 1000h; seg1 lim 10h base 2000h;
    // seg2 lim 0 base 3000h; seg3 lim 100h base FFF0h
    localparam vec_t VEC [10] = '{
        '{4'd0, 12'd5,    16'h1005, 1'b0, 2'd2, 2'd3},
        '{4'd0, 12'd99,   16'h1063, 1'b0, 2'd2, 2'd3},
        '{4'd0, 12'd100,  16'h0000, 1'b1, 2'd1, 2'd2},
        '{4'd1, 12'h00f,  16'h200f, 1'b0, 2'd2, 2'd3},
        '{4'd1, 12'h010,  16'h0000, 1'b1, 2'd1, 2'd2},
        '{4'd2, 12'h000,  16'h0000, 1'b1, 2'd1, 2'd2},
        '{4'd3, 12'h020,  16'h0010, 1'b0, 2'd2, 2'd3},
        '{4'd3, 12'h0ff,  16'h00ef, 1'b0, 2'd2, 2'd3},
        '{4'd4, 12'h000,  16'h0000, 1'b1, 2'd0, 2'd0},
        '{4'd15, 12'h001, 16'h0000, 1'b1, 2'd0, 2'd0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int a, rd, lt;
        bit f;
        for (int i = 0; i < 64; i++) tmem[i] = '0;
        tmem[8]  = 16'd100;  tmem[9]  = 16'h1000;
        tmem[10] = 16'h0010; tmem[11] = 16'h2000;
        tmem[12] = 16'h0000; tmem[13] = 16'h3000;
        tmem[14] = 16'h0100; tmem[15] = 16'hfff0;
        tmem[20] = 16'd50;   tmem[21] = 16'h4000;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!rsp_valid && req_ready && !mem_rd_en, "R1 reset outputs", int'(rsp_valid), 0);
        xlate(0, 0, a, f, rd, lt);
        check(f == 1'b1, "R1 size zero after reset faults", int'(f), 1);
        check(rd == 0, "R1 no reads with size zero", rd, 0);

        cfg_write(1'b0, 8);
        cfg_write(1'b1, 4);

        foreach (VEC[i]) begin
            xlate(int'(VEC[i].seg), int'(VEC[i].off), a, f, rd, lt);
            check(f == VEC[i].flt, "R2/R4/R5 fault flag", int'(f), int'(VEC[i].flt));
            check(a == int'(VEC[i].addr), "R5/R8 address", a, int'(VEC[i].addr));
            check(rd == int'(VEC[i].reads), "R2/R4 read count", rd, int'(VEC[i].reads));
            check(lt == int'(VEC[i].lat), "R2/R4/R5 latency", lt, int'(VEC[i].lat));
            if (VEC[i].reads == 2'd2) begin
                check(int'(prev_ra) == 8 + 2*int'(VEC[i].seg), "R3 limit word address",
                      int'(prev_ra), 8 + 2*int'(VEC[i].seg));
                check(int'(last_ra) == 9 + 2*int'(VEC[i].seg), "R3 base word address",
                      int'(last_ra), 9 + 2*int'(VEC[i].seg));
            end
            if (VEC[i].reads == 2'd1)
                check(int'(last_ra) == 8 + 2*int'(VEC[i].seg), "R4 only limit read",
                      int'(last_ra), 8 + 2*int'(VEC[i].seg));
        end

        // R7: a size write during a translation is dropped
        @(negedge clk);
        req_valid = 1'b1; req_seg = 4'd1; req_off = 12'h3;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = '0;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        while (!rsp_valid) @(negedge clk);
        check(!rsp_fault && rsp_addr == 16'h2003, "R7 in-flight result", int'(rsp_addr), 16'h2003);
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
        xlate(3, 1, a, f, rd, lt);
        check(!f && a == 16'hfff1, "R7 busy write dropped", a, 16'hfff1);

        // R7: req_ready drops during a write cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 10'd1;
        #1;
        check(!req_ready, "R7 req_ready low on write", int'(req_ready), 0);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        xlate(1, 0, a, f, rd, lt);
        check(f && rd == 0, "R7 idle size write applied", int'(f), 1);

        // R7: context switch by rewriting the origin
        cfg_write(1'b0, 20);
        xlate(0, 7, a, f, rd, lt);
        check(!f && a == 16'h4007, "R7 new origin used", a, 16'h4007);
        check(int'(prev_ra) == 20 && int'(last_ra) == 21, "R3 new origin addresses", int'(prev_ra), 20);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule